// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM alive by running refresh cycles in which the column strobe falls before the row strobe. In this kind of cycle the memory uses its own internal row counter, so the block never drives an address. The block shares the memory pins with an access controller. It asks for them with a level request and drives the strobes only after the controller grants them. It lets the pins go again once the row strobe precharge has finished.

After reset the block keeps every request off the bus for a programmable power-up pause. It then runs a fixed burst of warm-up refresh cycles and only after that raises a ready flag for normal traffic. From then on an interval timer adds one pending refresh per period, with the period set to the refresh window divided by the number of rows. A saturating pending counter lets refreshes be postponed while the bus is busy. When the counter reaches its limit, an urgency output asks the controller to grant the bus at once.

All timings are given in clock cycles through parameters. The integrator chooses them so that each strobe phase meets the memory's minimum widths at the chosen clock.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied, and for PAUSE_CYC cycles after the internal reset release (two clock edges after rst_n rises), bus_req, pin_drive_en and mem_ready are 0, and ras_n, cas_n and we_n are 1.
- R2: After the pause, exactly WARMUP_CNT refresh cycles run. mem_ready rises on the clock edge that ends the last of them and then stays 1 until reset.
- R3: In each refresh cycle cas_n is low for CSR_CYC cycles with ras_n still high. Both are then low together for RAS_CYC cycles, and both rise on the same edge.
- R4: After ras_n rises, the pins stay driven with ras_n and cas_n high for RP_CYC cycles. The pins are then released.
- R5: pin_drive_en rises only on the edge after bus_grant is seen high while requesting. The first PRE_CYC driven cycles keep cas_n high before it falls.
- R6: bus_req rises on the edge after a refresh is owed while the block is idle. It stays high without a grant, and falls on the edge that ends the refresh cycle.
- R7: Once ready, one refresh is added to the pending count every INTERVAL_CYC cycles. The first is added INTERVAL_CYC cycles after ready rises. A completed cycle removes one.
- R8: The pending count saturates at MAX_PEND, and ticks that arrive beyond that are dropped. refresh_urgent is 1 exactly while the count equals MAX_PEND.
- R9: we_n is 1 in every cycle, so that every refresh is read as a refresh rather than a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_grant | input | 1 | Controller hands the memory pins to this block |
| bus_req | output | 1 | Request for the memory pins |
| refresh_urgent | output | 1 | Pending refresh count is at its limit |
| pin_drive_en | output | 1 | This block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| mem_ready | output | 1 | Pause and warm-up finished |

## Verification
The assertions assume the controller never withdraws bus_grant while the block is driving the pins. They also assume the grant stays low while no request is pending. The stimulus follows both rules: it lowers the grant only after it sees bus_req fall, and otherwise grants either at once, at random, or not at all for a long stretch. The long stretch without a grant drives the pending counter into saturation and makes it drop ticks. After that the random phase drains the backlog.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_PRE,
    SQ_CSR,
    SQ_RAS,
    SQ_RP
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_WARM,
    PH_RUN
  } init_phase_t;
endpackage

// File: rtl/rfsh_init_ctrl.sv
module rfsh_init_ctrl
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC  = 20000,
  parameter int WARMUP_CNT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        refresh_done,
  output init_phase_t phase
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int WW = $clog2(WARMUP_CNT + 1);

  init_phase_t ph_q, ph_d;
  logic [PW-1:0] pause_q, pause_d;
  logic [WW-1:0] warm_q, warm_d;
  logic pause_en, warm_en;

  always_comb begin
    ph_d     = ph_q;
    pause_d  = pause_q;
    warm_d   = warm_q;
    pause_en = 1'b0;
    warm_en  = 1'b0;
    unique case (ph_q)
      PH_PAUSE: begin
        pause_en = 1'b1;
        if (pause_q == PW'(PAUSE_CYC - 1)) begin
          ph_d    = PH_WARM;
          warm_en = 1'b1;
          warm_d  = WW'(WARMUP_CNT);
        end else begin
          pause_d = pause_q + PW'(1);
        end
      end
      PH_WARM: begin
        if (refresh_done) begin
          warm_en = 1'b1;
          if (warm_q == WW'(1)) ph_d = PH_RUN;
          warm_d = warm_q - WW'(1);
        end
      end
      default: ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_PAUSE;
      pause_q <= '0;
      warm_q  <= '0;
    end else begin
      ph_q <= ph_d;
      if (pause_en) pause_q <= pause_d;
      if (warm_en)  warm_q  <= warm_d;
    end
  end

  assign phase = ph_q;

  p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_RUN |=> ph_q == PH_RUN);
  p_warm_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_WARM |-> warm_q != '0);
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL_CYC + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == TW'(INTERVAL_CYC - 1));
    cnt_d = (!run || tick) ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < TW'(INTERVAL_CYC));
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add,
  input  logic sub,
  output logic any,
  output logic urgent
);
  localparam int CW = $clog2(MAX_PEND + 1);

  logic [CW-1:0] pend_q, pend_d;
  logic pend_en;

  always_comb begin
    pend_en = add ^ sub;
    pend_d  = pend_q;
    if (add && !sub) begin
      if (pend_q != CW'(MAX_PEND)) pend_d = pend_q + CW'(1);
    end else if (sub && !add) begin
      pend_d = pend_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign any    = (pend_q != '0);
  assign urgent = (pend_q == CW'(MAX_PEND));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= CW'(MAX_PEND));
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sub |-> pend_q != '0);
  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && add && !sub) |=> urgent);
endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
  import rfsh_pkg::*;
#(
  parameter int PRE_CYC = 1,
  parameter int CSR_CYC = 1,
  parameter int RAS_CYC = 6,
  parameter int RP_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic need,
  input  logic bus_grant,
  output logic bus_req,
  output logic drive_en,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic done
);
  localparam int M1   = (PRE_CYC > CSR_CYC) ? PRE_CYC : CSR_CYC;
  localparam int M2   = (RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC;
  localparam int MAXL = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXL + 1);

  seq_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b1;
    done   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        cnt_en = 1'b0;
        if (need) st_d = SQ_REQ;
      end
      SQ_REQ: begin
        if (bus_grant) begin
          st_d  = SQ_PRE;
          cnt_d = CW'(PRE_CYC - 1);
        end else cnt_en = 1'b0;
      end
      SQ_PRE: begin
        if (cnt_q == '0) begin
          st_d  = SQ_CSR;
          cnt_d = CW'(CSR_CYC - 1);
        end else cnt_d = cnt_q - CW'(1);
      end
      SQ_CSR: begin
        if (cnt_q == '0) begin
          st_d  = SQ_RAS;
          cnt_d = CW'(RAS_CYC - 1);
        end else cnt_d = cnt_q - CW'(1);
      end
      SQ_RAS: begin
        if (cnt_q == '0) begin
          st_d  = SQ_RP;
          cnt_d = CW'(RP_CYC - 1);
        end else cnt_d = cnt_q - CW'(1);
      end
      SQ_RP: begin
        if (cnt_q == '0) begin
          st_d = SQ_IDLE;
          done = 1'b1;
        end else cnt_d = cnt_q - CW'(1);
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign bus_req  = (st_q != SQ_IDLE);
  assign drive_en = (st_q == SQ_PRE) || (st_q == SQ_CSR) || (st_q == SQ_RAS) || (st_q == SQ_RP);
  assign cas_n    = !((st_q == SQ_CSR) || (st_q == SQ_RAS));
  assign ras_n    = !(st_q == SQ_RAS);
  assign we_n     = 1'b1;

  // R3: the column strobe is already low on the edge where the row strobe falls
  p_cas_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n) && !cas_n);
  p_strobes_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $rose(cas_n));
  p_precharge_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> drive_en);
  p_grant_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> bus_grant);
  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_grant) |=> bus_req);
  p_drive_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> $past(bus_req) && $past(bus_grant));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int WARMUP_CNT   = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_PEND     = 8,
  parameter int PRE_CYC      = 1,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 6,
  parameter int RP_CYC       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_grant,
  output logic bus_req,
  output logic refresh_urgent,
  output logic pin_drive_en,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic mem_ready
);
  logic [1:0] sync_q;
  logic rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i_n = sync_q[1];

  init_phase_t phase;
  logic done, tick, pend_any, need, run;

  assign run  = (phase == PH_RUN);
  assign need = (phase == PH_WARM) || pend_any;

  rfsh_init_ctrl #(.PAUSE_CYC(PAUSE_CYC), .WARMUP_CNT(WARMUP_CNT)) u_init (
    .clk(clk), .rst_n(rst_i_n), .refresh_done(done), .phase(phase));

  rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .run(run), .tick(tick));

  rfsh_pending_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk(clk), .rst_n(rst_i_n), .add(tick), .sub(done && run),
    .any(pend_any), .urgent(refresh_urgent));

  rfsh_strobe_seq #(.PRE_CYC(PRE_CYC), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .need(need), .bus_grant(bus_grant),
    .bus_req(bus_req), .drive_en(pin_drive_en), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .done(done));

  assign mem_ready = run;

  p_quiet_pause_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    phase == PH_PAUSE |-> !bus_req && !pin_drive_en);
  p_urgent_only_ready_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    refresh_urgent |-> mem_ready);
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam time CLK_PERIOD = 10ns;
  localparam int PAUSE = 50, WARM = 8, INTV = 40, MAXP = 8;
  localparam int PRE = 2, CSR = 1, RASC = 6, RP = 4;
  localparam int L = PRE + CSR + RASC + RP;

  logic clk = 1'b0, rst_n = 1'b0, bus_grant = 1'b0;
  logic bus_req, refresh_urgent, pin_drive_en, ras_n, cas_n, we_n, mem_ready;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_refresh_sched #(.PAUSE_CYC(PAUSE), .WARMUP_CNT(WARM), .INTERVAL_CYC(INTV), .MAX_PEND(MAXP),
    .PRE_CYC(PRE), .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RP)) uut (
    .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .bus_req(bus_req),
    .refresh_urgent(refresh_urgent), .pin_drive_en(pin_drive_en), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .mem_ready(mem_ready));

  int checks = 0, fails = 0, cyc = 0, gmode = 0;
  bit finished = 1'b0, saw_urgent = 1'b0, prev_cas = 1'b1;
  int warm_falls = 0;

  // behavioural reference
  int m_sync, m_phase, m_pc, m_warm, m_pend, m_tc, m_pos;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_phase = 0; m_pc = 0; m_warm = 0; m_pend = 0; m_tc = 0; m_pos = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit done, need, tick;
      int np;
      done = (m_pos == L + 1);
      need = (m_phase == 1) || (m_pend != 0);
      tick = (m_phase == 2) && (m_tc == INTV - 1);
      if (m_pos == 0) np = need ? 1 : 0;
      else if (m_pos == 1) np = bus_grant ? 2 : 1;
      else if (done) np = 0;
      else np = m_pos + 1;
      if (m_phase == 2) begin
        if (tick && !done) m_pend = (m_pend < MAXP) ? m_pend + 1 : MAXP;
        else if (done && !tick) m_pend = m_pend - 1;
        m_tc = tick ? 0 : m_tc + 1;
      end else m_tc = 0;
      if (m_phase == 0) begin
        if (m_pc == PAUSE - 1) begin m_phase = 1; m_warm = WARM; end
        else m_pc++;
      end else if (m_phase == 1 && done) begin
        if (m_warm == 1) m_phase = 2;
        m_warm--;
      end
      m_pos = np;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      int o;
      bit e_cas, e_ras;
      cyc++;
      o = m_pos - 2;
      e_cas = (m_pos >= 2) && (o >= PRE) && (o < PRE + CSR + RASC);
      e_ras = (m_pos >= 2) && (o >= PRE + CSR) && (o < PRE + CSR + RASC);
      chk("R3 cas_n", cas_n, !e_cas);
      chk("R4 ras_n", ras_n, !e_ras);
      chk("R5 pin_drive_en", pin_drive_en, m_pos >= 2);
      chk(m_phase == 2 ? "R7 bus_req" : "R6 bus_req", bus_req, m_pos != 0);
      chk(m_phase == 0 ? "R1 mem_ready" : "R2 mem_ready", mem_ready, m_phase == 2);
      chk("R8 refresh_urgent", refresh_urgent, m_pend == MAXP);
      chk("R9 we_n", we_n, 1'b1);
      if (refresh_urgent) saw_urgent = 1'b1;
      if (prev_cas && !cas_n && !mem_ready) warm_falls++;
      prev_cas = cas_n;
    end
    // grant policy: drop only after the request falls, keep once given
    if (!bus_req) bus_grant = 1'b0;
    else if (!bus_grant) begin
      case (gmode)
        0: bus_grant = 1'b1;
        1: bus_grant = 1'b0;
        default: bus_grant = ($urandom_range(0, 3) == 0);
      endcase
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset bus_req", bus_req, 1'b0);
    chk("R1 reset drive", pin_drive_en, 1'b0);
    chk("R1 reset ras_n", ras_n, 1'b1);
    chk("R1 reset cas_n", cas_n, 1'b1);
    chk("R1 reset ready", mem_ready, 1'b0);
    rst_n = 1'b1;
    gmode = 0;
    repeat (PAUSE + 300) @(negedge clk);
    chk("R2 ready after warm-up", mem_ready, 1'b1);
    checks++;
    if (warm_falls != WARM) begin
      fails++;
      $display("FAIL R2 warm-up cycles: got %0d expected %0d", warm_falls, WARM);
    end
    gmode = 1;
    repeat (INTV * 12) @(negedge clk);
    chk("R8 saturated urgent", saw_urgent, 1'b1);
    gmode = 2;
    repeat (3000) @(negedge clk);
    chk("R8 backlog drained", refresh_urgent, 1'b0);
    gmode = 0;
    repeat (500) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule